// File: doc/BRIEF.md
# Pin-Kicked Watchdog Supervisor

This block supervises a single kick line from the outside world. It keeps a service counter that advances once per millisecond tick enable. When the counter reaches a programmed margin, the block drives a reset output for a fixed number of clock cycles. A host keeps the system alive by servicing the kick line in time.

Two service algorithms are selectable.

- **Toggle algorithm:** every transition of the kick line, whether rising or falling, restarts the count. A separate line-driven input stands in for an undriven line. While that input is low, the supervisor is idle.
- **Level algorithm:** the count runs only while the line sits at its active level. Driving the opposite level switches supervision off and clears the count. The active level is chosen by a polarity input.

The kick line is asynchronous. It passes through a synchronizer before any edge or level is examined. If the algorithm select or the margin changes, the count restarts, so reprogramming cannot trigger a reset by accident.

Top module: `pin_wdg_top`

## Requirements
- R1: In the toggle algorithm (alg_level_i = 0) with line_driven_i = 1 and margin M ≥ 1, the M-th tick after the last clear starts a reset pulse in the cycle that follows the clock edge sampling that tick. Ticks 1 to M-1 leave wdg_reset_o low.
- R2: In the toggle algorithm, a rising transition of kick_i clears the count, and so does a falling transition.
- R3: In the toggle algorithm, while line_driven_i = 0 the count is held at zero and no reset is produced, however many ticks arrive. After line_driven_i returns to 1, counting starts again from zero.
- R4: wdg_reset_o is low after reset. Each reset pulse is high for exactly 16 clock cycles. Ticks that arrive during a pulse are not counted, and the count restarts from zero once the pulse ends.
- R5: In the level algorithm (alg_level_i = 1) with kick_act_high_i = 1, holding kick_i high runs the count. The M-th tick starts a pulse, and counting repeats after each pulse for as long as the level is held.
- R6: In the level algorithm, holding kick_i at the inactive level clears the count and blocks all resets. line_driven_i has no effect in this algorithm.
- R7: With kick_act_high_i = 0 in the level algorithm, kick_i = 0 is the active (running) level and kick_i = 1 is the inactive level.
- R8: A change of margin_ms_i or of alg_level_i clears the count.
- R9: A margin of 1 fires on the first tick. A margin of 0 behaves as a margin of 1.
- R10: The count advances only on cycles where tick_ms_i = 1. Any number of clock cycles without a tick leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kick_i | input | 1 | Asynchronous kick line |
| alg_level_i | input | 1 | 0 = toggle algorithm, 1 = level algorithm |
| kick_act_high_i | input | 1 | Level algorithm: 1 = high is the active level, 0 = low is the active level |
| line_driven_i | input | 1 | Toggle algorithm: 1 = line is driven (supervision on), 0 = supervisor idle |
| margin_ms_i | input | MARGIN_W | Service margin in ticks (milliseconds) |
| tick_ms_i | input | 1 | One-cycle enable, once per millisecond |
| wdg_reset_o | output | 1 | Reset pulse, active high, 16 cycles long |

## Verification
The assertions assume the following about the inputs:

- margin_ms_i, alg_level_i, kick_act_high_i and line_driven_i are synchronous to clk.
- tick_ms_i is a single-cycle strobe.
- The kick line is the only asynchronous input.

The stimulus follows these rules:

- It changes every input on the falling clock edge.
- It raises the tick for one cycle at a time.
- After a kick change, it waits three cycles (synchronizer plus edge detector) before the next tick.
- After a configuration change, it waits two cycles before the next tick.

This means no tick ever races a pending clear.

// File: rtl/pin_wdg_pkg.sv
package pin_wdg_pkg;

  typedef enum logic {
    ALG_TOGGLE = 1'b0,
    ALG_LEVEL  = 1'b1
  } wdg_alg_e;

  typedef struct packed {
    logic run;
    logic clr;
  } wdg_ctl_t;

endpackage

// File: rtl/pin_wdg_rst_sync.sv
module pin_wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pin_wdg_kick_sync.sv
module pin_wdg_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_async,
  output logic kick_lvl,
  output logic kick_edge
);

  logic [STAGES-1:0] stage_q;
  logic              stage_d_first;
  logic              last_q;
  logic              last_d;

  always_comb begin
    stage_d_first = kick_async;
    last_d        = stage_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q[0] <= 1'b0;
    end else begin
      stage_q[0] <= stage_d_first;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= 1'b0;
      end else begin
        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
    end else begin
      last_q <= last_d;
    end
  end

  assign kick_lvl  = stage_q[STAGES-1];
  assign kick_edge = stage_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/pin_wdg_ctrl.sv
module pin_wdg_ctrl
  import pin_wdg_pkg::*;
#(
  parameter int MARGIN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alg_level,
  input  logic                act_high,
  input  logic                line_driven,
  input  logic [MARGIN_W-1:0] margin,
  input  logic                kick_lvl,
  input  logic                kick_edge,
  output wdg_ctl_t            ctl,
  output logic                cfg_change
);

  wdg_alg_e            alg;
  wdg_alg_e            alg_q;
  logic [MARGIN_W-1:0] margin_q;
  logic                level_active;

  always_comb begin
    alg          = wdg_alg_e'(alg_level);
    level_active = (kick_lvl == act_high);
    cfg_change   = (alg != alg_q) || (margin != margin_q);
    ctl.run      = 1'b0;
    ctl.clr      = cfg_change;
    unique case (alg)
      ALG_TOGGLE: begin
        ctl.run = line_driven;
        if (kick_edge) begin
          ctl.clr = 1'b1;
        end
      end
      ALG_LEVEL: begin
        ctl.run = level_active;
      end
      default: begin
        ctl.run = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alg_q    <= ALG_TOGGLE;
      margin_q <= '0;
    end else begin
      alg_q    <= alg;
      margin_q <= margin;
    end
  end

endmodule

// File: rtl/pin_wdg_count.sv
module pin_wdg_count #(
  parameter int MARGIN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                run,
  input  logic                clr,
  input  logic                hold,
  input  logic [MARGIN_W-1:0] margin,
  output logic [MARGIN_W-1:0] cnt,
  output logic                expire
);

  localparam logic [MARGIN_W:0] ONE_W = {{MARGIN_W{1'b0}}, 1'b1};

  logic [MARGIN_W-1:0] cnt_q;
  logic [MARGIN_W-1:0] cnt_d;
  logic [MARGIN_W:0]   eff_margin;
  logic [MARGIN_W:0]   cnt_inc;
  logic                step;

  always_comb begin
    eff_margin = (margin == '0) ? ONE_W : {1'b0, margin};
    cnt_inc    = {1'b0, cnt_q} + ONE_W;
    step       = run && !clr && !hold && tick;
    expire     = step && (cnt_inc >= eff_margin);
    if (clr || !run) begin
      cnt_d = '0;
    end else if (expire) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_inc[MARGIN_W-1:0];
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pin_wdg_pulse.sv
module pin_wdg_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy,
  output logic pulse
);

  localparam int PCW = $clog2(PULSE_LEN + 1);
  localparam logic [PCW-1:0] LOAD = PCW'(PULSE_LEN);

  logic [PCW-1:0] pcnt_q;
  logic [PCW-1:0] pcnt_d;
  logic [PCW:0]   hi_q;

  always_comb begin
    if (fire && (pcnt_q == '0)) begin
      pcnt_d = LOAD;
    end else if (pcnt_q != '0) begin
      pcnt_d = pcnt_q - 1'b1;
    end else begin
      pcnt_d = pcnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

  assign busy  = (pcnt_q != '0);
  assign pulse = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (pulse) begin
      hi_q <= hi_q + 1'b1;
    end else begin
      hi_q <= '0;
    end
  end

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> (hi_q == (PCW+1)'(PULSE_LEN)));

  // R4
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (hi_q < (PCW+1)'(PULSE_LEN)));

  // R1
  fire_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !busy) |=> pulse);

endmodule

// File: rtl/pin_wdg_top.sv
module pin_wdg_top
  import pin_wdg_pkg::*;
#(
  parameter int MARGIN_W  = 16,
  parameter int PULSE_LEN = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kick_i,
  input  logic                alg_level_i,
  input  logic                kick_act_high_i,
  input  logic                line_driven_i,
  input  logic [MARGIN_W-1:0] margin_ms_i,
  input  logic                tick_ms_i,
  output logic                wdg_reset_o
);

  logic                rst_sync_n;
  logic                kick_lvl;
  logic                kick_edge;
  wdg_ctl_t            ctl;
  logic                cfg_change;
  logic [MARGIN_W-1:0] cnt;
  logic                expire;
  logic                busy;

  pin_wdg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pin_wdg_kick_sync #(.STAGES(SYNC_LEN)) i_kick_sync (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .kick_async (kick_i),
    .kick_lvl   (kick_lvl),
    .kick_edge  (kick_edge)
  );

  pin_wdg_ctrl #(.MARGIN_W(MARGIN_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .alg_level   (alg_level_i),
    .act_high    (kick_act_high_i),
    .line_driven (line_driven_i),
    .margin      (margin_ms_i),
    .kick_lvl    (kick_lvl),
    .kick_edge   (kick_edge),
    .ctl         (ctl),
    .cfg_change  (cfg_change)
  );

  pin_wdg_count #(.MARGIN_W(MARGIN_W)) i_count (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick_ms_i),
    .run    (ctl.run),
    .clr    (ctl.clr),
    .hold   (busy),
    .margin (margin_ms_i),
    .cnt    (cnt),
    .expire (expire)
  );

  pin_wdg_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fire  (expire),
    .busy  (busy),
    .pulse (wdg_reset_o)
  );

  // R2
  toggle_edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!alg_level_i && kick_edge) |=> (cnt == '0));

  // R3
  undriven_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!alg_level_i && !line_driven_i) |=> (cnt == '0));

  // R6
  level_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alg_level_i && (kick_lvl != kick_act_high_i)) |=> (cnt == '0));

  // R8
  cfg_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_change |=> (cnt == '0));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick_ms_i |=> ($stable(cnt) || (cnt == '0)));

  // R4
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(wdg_reset_o) |-> $past(expire));

endmodule

// File: tb/test_pin_wdg_top.sv
module test_pin_wdg_top;

  localparam int CLK_PERIOD = 10;
  localparam int MW         = 16;
  localparam int PLEN       = 16;
  localparam int MAX_CYC    = 100000;

  logic          clk;
  logic          rst_n;
  logic          kick;
  logic          alg_level;
  logic          act_high;
  logic          driven;
  logic [MW-1:0] margin;
  logic          tick;
  logic          wrst;

  int cyc;
  int n_tests;
  int n_fail;

  typedef struct {
    int    start;
    string req;
  } exp_t;

  exp_t exp_q[$];

  pin_wdg_top #(.MARGIN_W(MW), .PULSE_LEN(PLEN), .SYNC_LEN(2)) i_pin_wdg_top (
    .clk             (clk),
    .rst_n           (rst_n),
    .kick_i          (kick),
    .alg_level_i     (alg_level),
    .kick_act_high_i (act_high),
    .line_driven_i   (driven),
    .margin_ms_i     (margin),
    .tick_ms_i       (tick),
    .wdg_reset_o     (wrst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: measures every pulse and compares it with the expected item
  logic mon_prev;
  int   mon_start;
  int   mon_len;

  always @(negedge clk) begin
    if (!rst_n) begin
      mon_prev <= 1'b0;
      mon_len  <= 0;
    end else begin
      if (wrst && !mon_prev) begin
        mon_start <= cyc;
        mon_len   <= 1;
      end else if (wrst) begin
        mon_len <= mon_len + 1;
      end
      if (!wrst && mon_prev) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected pulse at cycle %0d len %0d (expected none)", mon_start, mon_len);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.start != mon_start || mon_len != PLEN) begin
            n_fail++;
            $display("FAIL %s/R4 pulse start %0d len %0d (expected start %0d len %0d)",
                     e.req, mon_start, mon_len, e.start, PLEN);
          end
        end
      end
      mon_prev <= wrst;
    end
  end

  task automatic check_rst(input logic exp, input string req);
    n_tests++;
    if (wrst !== exp) begin
      n_fail++;
      $display("FAIL %s reset_o=%b (expected %b)", req, wrst, exp);
    end
  endtask

  // Driver: one tick; a firing tick pushes its expected pulse start
  task automatic tick_once(input bit fire, input string req);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (fire) begin
      exp_t e;
      e.start = cyc;
      e.req   = req;
      exp_q.push_back(e);
      check_rst(1'b1, req);
    end else begin
      check_rst(1'b0, req);
    end
  endtask

  task automatic ticks_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) tick_once(1'b0, req);
  endtask

  task automatic raw_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic set_cfg(input logic lv, input logic ah, input logic dr, input int m);
    @(negedge clk);
    alg_level = lv;
    act_high  = ah;
    driven    = dr;
    margin    = MW'(m);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_kick(input logic v);
    @(negedge clk) kick = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  bit timed_out;

  initial begin
    cyc = 0; n_tests = 0; n_fail = 0; timed_out = 0;
    rst_n = 1'b0; kick = 1'b0; alg_level = 1'b0; act_high = 1'b1;
    driven = 1'b0; margin = '0; tick = 1'b0;
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_rst(1'b0, "R4 reset state");

        // R1: toggle timeout after margin ticks
        set_cfg(1'b0, 1'b1, 1'b1, 5);
        ticks_quiet(4, "R1");
        tick_once(1'b1, "R1");
        settle();

        // R2: rising and falling edges both clear
        ticks_quiet(4, "R2");
        set_kick(1'b1);
        ticks_quiet(4, "R2 rise");
        set_kick(1'b0);
        ticks_quiet(4, "R2 fall");
        tick_once(1'b1, "R2");
        settle();

        // R3: undriven line idles the supervisor
        set_cfg(1'b0, 1'b1, 1'b0, 5);
        ticks_quiet(10, "R3 idle");
        set_cfg(1'b0, 1'b1, 1'b1, 5);
        ticks_quiet(4, "R3");
        tick_once(1'b1, "R3");
        settle();

        // R4: ticks inside a pulse are ignored, count restarts after it
        ticks_quiet(4, "R4");
        tick_once(1'b1, "R4");
        raw_tick(); raw_tick(); raw_tick();
        repeat (14) @(negedge clk);
        ticks_quiet(4, "R4 restart");
        tick_once(1'b1, "R4");
        settle();

        // R5: level algorithm, active high, repeats while held
        set_cfg(1'b1, 1'b1, 1'b1, 3);
        ticks_quiet(3, "R5 inactive");
        set_kick(1'b1);
        ticks_quiet(2, "R5");
        tick_once(1'b1, "R5");
        settle();
        ticks_quiet(2, "R5 repeat");
        tick_once(1'b1, "R5 repeat");
        settle();

        // R6: inactive level blocks, line_driven_i ignored
        ticks_quiet(2, "R6");
        set_kick(1'b0);
        ticks_quiet(10, "R6 off");
        set_cfg(1'b1, 1'b1, 1'b0, 3);
        set_kick(1'b1);
        ticks_quiet(2, "R6 driven ignored");
        tick_once(1'b1, "R6");
        settle();

        // R7: active-low polarity
        set_cfg(1'b1, 1'b0, 1'b0, 3);
        ticks_quiet(5, "R7 high inactive");
        set_kick(1'b0);
        ticks_quiet(2, "R7");
        tick_once(1'b1, "R7");
        settle();

        // R8: margin change and algorithm change clear the count
        set_cfg(1'b0, 1'b1, 1'b1, 6);
        ticks_quiet(5, "R8");
        set_cfg(1'b0, 1'b1, 1'b1, 7);
        ticks_quiet(6, "R8 margin");
        tick_once(1'b1, "R8");
        settle();
        set_cfg(1'b0, 1'b0, 1'b1, 4);
        ticks_quiet(3, "R8");
        set_cfg(1'b1, 1'b0, 1'b1, 4);
        ticks_quiet(3, "R8 alg");
        tick_once(1'b1, "R8 alg");
        settle();

        // R9: margin boundaries
        set_cfg(1'b0, 1'b1, 1'b1, 1);
        tick_once(1'b1, "R9 m1");
        settle();
        set_cfg(1'b0, 1'b1, 1'b1, 0);
        tick_once(1'b1, "R9 m0");
        settle();

        // R10: no tick, no progress
        set_cfg(1'b0, 1'b1, 1'b1, 3);
        ticks_quiet(2, "R10");
        repeat (200) @(negedge clk);
        check_rst(1'b0, "R10 wait");
        tick_once(1'b1, "R10");
        settle();
      end
      begin
        repeat (MAX_CYC) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;

    if (timed_out) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired (expected completion within %0d cycles)", MAX_CYC);
    end
    while (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      n_fail++;
      $display("FAIL %s missing pulse (expected start %0d)", e.req, e.start);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule